// File: doc/BRIEF.md
# Cache Line Fill and Flush Controller

This block decides, for each bus cycle a processor core starts, whether a read becomes a multi-transfer cache line fill and whether the filled line is finally written into the on-chip cache. A read that the core marks cacheable, that is not part of a locked sequence and that sees the active-low cache-enable input asserted when the cycle starts becomes a fill. The fill then counts ready strobes to find its last transfer. The line is committed only if cache-enable was asserted in the clock before that final ready.

The block also turns an asynchronous active-low flush request into a single-clock invalidate-all pulse. If the request is held asserted across the release of reset, the block enters a three-state test mode instead of flushing. A third part produces the page cache-disable and write-through attribute outputs. It picks page-entry bits or control-register bits, masks cache-disable with the global cache-disable bit, and latches the result when a cycle starts, so the attributes follow the cycle-type timing. An output-enable drops while another master holds the bus.

Top module: `cache_fill_ctrl`

## Requirements
- R1: When a cycle is accepted with `read_i`=1, `cacheable_i`=1, `locked_i`=0 and `cache_en_ni`=0 at the accepting edge, `fill_active_o` is 1 from that edge until the edge that samples the fourth `rdy_i`=1, and is 0 after it. Wait clocks with `rdy_i`=0 do not count.
- R2: A cycle accepted with any of those conditions unmet keeps `fill_active_o` at 0 and ends on its first `rdy_i`=1.
- R3: A cycle accepted with `locked_i`=1 never becomes a fill, whatever the state of `cache_en_ni`.
- R4: `line_commit_o` is 1 for exactly one clock after the edge that samples the last ready of a fill, and only if `cache_en_ni` was 0 at the edge before that one. Otherwise it stays 0.
- R5: A low level on `flush_ni` first seen at edge k, even if it lasts only one clock, gives `flush_o`=1 for exactly one clock after edge k+2. This follows a two-stage synchronizer and falling-edge detection.
- R6: If the synchronized `flush_ni` is low at the last edge with `rst_ni`=0, then `test_mode_o` is 1 after reset is released, no `flush_o` pulse follows, and `test_mode_o` holds until the next reset. If it is high there, `test_mode_o` is 0.
- R7: At each accepted cycle start, `pcd_o`/`pwt_o` take the page-entry bits when `paging_en_i`=1 and `unpaged_i`=0, and the control-register bits otherwise. They hold that value until the next accepted start. A start requested while a cycle is in progress is ignored.
- R8: `pcd_o` is 0 for any cycle accepted with `cache_dis_i`=1. `pwt_o` is unaffected.
- R9: `attr_oe_o` is 0 the clock after `hold_i` is sampled 1, and 1 the clock after it is sampled 0.
- R10: While `rst_ni` is 0, `fill_active_o`, `line_commit_o`, `flush_o`, `pcd_o` and `pwt_o` are 0 and `attr_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cycle_start_i | input | 1 | Core requests a new bus cycle |
| read_i | input | 1 | Requested cycle is a read |
| cacheable_i | input | 1 | Core considers the cycle cacheable |
| locked_i | input | 1 | Cycle is part of a locked sequence |
| cache_en_ni | input | 1 | Active-low external cache enable |
| rdy_i | input | 1 | Bus transfer complete |
| flush_ni | input | 1 | Asynchronous active-low flush request |
| paging_en_i | input | 1 | Paging enabled |
| unpaged_i | input | 1 | Cycle bypasses paging |
| pg_pcd_i | input | 1 | Page-entry cache-disable bit |
| pg_pwt_i | input | 1 | Page-entry write-through bit |
| cr_pcd_i | input | 1 | Control-register cache-disable bit |
| cr_pwt_i | input | 1 | Control-register write-through bit |
| cache_dis_i | input | 1 | Global cache-disable bit |
| hold_i | input | 1 | Another master holds the bus |
| fill_active_o | output | 1 | Line fill in progress |
| line_commit_o | output | 1 | Write the filled line into the cache |
| flush_o | output | 1 | Invalidate-all pulse |
| test_mode_o | output | 1 | Three-state test mode |
| pcd_o | output | 1 | Cache-disable attribute of the current cycle |
| pwt_o | output | 1 | Write-through attribute of the current cycle |
| attr_oe_o | output | 1 | Attribute outputs are driven |

## Verification
The hardest case is the commit decision. It depends on cache-enable one clock before the final ready, and not at that ready or at any earlier one. To reach it, the stimulus inserts a wait state inside each fill. It drives cache-enable with the opposite polarity on every beat except the one before the last ready, so a controller that samples on the wrong clock shows the wrong commit. Test mode needs the flush request held low through the whole reset and over its release, followed by a check that no flush pulse leaks out afterwards.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SINGLE = 2'd1,
    ST_FILL   = 2'd2
  } cfc_state_e;
endpackage

// File: rtl/cfc_flush_sync.sv
module cfc_flush_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_ni,
  output logic flush_o,
  output logic test_mode_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_low_q;
  logic                   flush_q;
  logic                   test_mode_q;
  logic                   flush_low;

  // synchronizer runs through reset so test mode can be captured
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) sync_q <= flush_ni;
    end else begin : g_many
      always_ff @(posedge clk_i) sync_q <= {sync_q[SYNC_STAGES-2:0], flush_ni};
    end
  endgenerate

  assign flush_low = ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i) begin
    prev_low_q <= flush_low;
    if (!rst_ni) test_mode_q <= flush_low;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_q <= 1'b0;
    else         flush_q <= flush_low & ~prev_low_q;
  end

  assign flush_o     = flush_q;
  assign test_mode_o = test_mode_q;

  assert_flush_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |=> !flush_q);
  assert_test_mode_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> $stable(test_mode_q));
endmodule

// File: rtl/cfc_fill_fsm.sv
module cfc_fill_fsm
  import cfc_pkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_start_i,
  input  logic read_i,
  input  logic cacheable_i,
  input  logic locked_i,
  input  logic cache_en_ni,
  input  logic rdy_i,
  output logic accept_o,
  output logic fill_active_o,
  output logic line_commit_o
);
  localparam int BW = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BW-1:0] LAST_BEAT = BW'(BEATS - 1);

  cfc_state_e    state_q, state_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          ken_q;
  logic          commit_q, commit_d;
  logic          fill_req;

  assign accept_o = (state_q == ST_IDLE) && cycle_start_i;
  assign fill_req = read_i & cacheable_i & ~locked_i & ~cache_en_ni;

  always_comb begin
    state_d  = state_q;
    beat_d   = beat_q;
    commit_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (cycle_start_i) begin
        beat_d  = '0;
        state_d = fill_req ? ST_FILL : ST_SINGLE;
      end
      ST_SINGLE: if (rdy_i) state_d = ST_IDLE;
      ST_FILL: if (rdy_i) begin
        if (beat_q == LAST_BEAT) begin
          state_d  = ST_IDLE;
          commit_d = ken_q; // enable seen one clock before final ready
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      beat_q   <= '0;
      ken_q    <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      beat_q   <= beat_d;
      ken_q    <= ~cache_en_ni;
      commit_q <= commit_d;
    end
  end

  assign fill_active_o = (state_q == ST_FILL);
  assign line_commit_o = commit_q;

  assert_locked_no_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && locked_i) |=> !fill_active_o);
  assert_commit_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |=> !commit_q);
  assert_commit_after_fill_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_q |-> $past(state_q == ST_FILL));
  assert_fill_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && fill_req) |=> fill_active_o);
endmodule

// File: rtl/cfc_attr_sel.sv
module cfc_attr_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic paging_en_i,
  input  logic unpaged_i,
  input  logic pg_pcd_i,
  input  logic pg_pwt_i,
  input  logic cr_pcd_i,
  input  logic cr_pwt_i,
  input  logic cache_dis_i,
  input  logic hold_i,
  output logic pcd_o,
  output logic pwt_o,
  output logic attr_oe_o
);
  logic use_page, pcd_d, pwt_d;
  logic pcd_q, pwt_q, oe_q;

  assign use_page = paging_en_i & ~unpaged_i;
  assign pcd_d    = (use_page ? pg_pcd_i : cr_pcd_i) & ~cache_dis_i;
  assign pwt_d    = use_page ? pg_pwt_i : cr_pwt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcd_q <= 1'b0;
      pwt_q <= 1'b0;
      oe_q  <= 1'b1;
    end else begin
      if (accept_i) begin
        pcd_q <= pcd_d;
        pwt_q <= pwt_d;
      end
      oe_q <= ~hold_i;
    end
  end

  assign pcd_o     = pcd_q;
  assign pwt_o     = pwt_q;
  assign attr_oe_o = oe_q;

  assert_pcd_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && cache_dis_i) |=> !pcd_q);
  assert_attr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept_i |=> ($stable(pcd_q) && $stable(pwt_q)));
  assert_oe_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !oe_q);
endmodule

// File: rtl/cache_fill_ctrl.sv
module cache_fill_ctrl #(
  parameter int BEATS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_start_i,
  input  logic read_i,
  input  logic cacheable_i,
  input  logic locked_i,
  input  logic cache_en_ni,
  input  logic rdy_i,
  input  logic flush_ni,
  input  logic paging_en_i,
  input  logic unpaged_i,
  input  logic pg_pcd_i,
  input  logic pg_pwt_i,
  input  logic cr_pcd_i,
  input  logic cr_pwt_i,
  input  logic cache_dis_i,
  input  logic hold_i,
  output logic fill_active_o,
  output logic line_commit_o,
  output logic flush_o,
  output logic test_mode_o,
  output logic pcd_o,
  output logic pwt_o,
  output logic attr_oe_o
);
  logic accept;

  cfc_fill_fsm #(.BEATS(BEATS)) u_fsm (
    .clk_i, .rst_ni, .cycle_start_i, .read_i, .cacheable_i, .locked_i,
    .cache_en_ni, .rdy_i,
    .accept_o      (accept),
    .fill_active_o (fill_active_o),
    .line_commit_o (line_commit_o)
  );

  cfc_flush_sync #(.SYNC_STAGES(SYNC_STAGES)) u_flush (
    .clk_i, .rst_ni, .flush_ni,
    .flush_o     (flush_o),
    .test_mode_o (test_mode_o)
  );

  cfc_attr_sel u_attr (
    .clk_i, .rst_ni,
    .accept_i (accept),
    .paging_en_i, .unpaged_i, .pg_pcd_i, .pg_pwt_i, .cr_pcd_i, .cr_pwt_i,
    .cache_dis_i, .hold_i,
    .pcd_o     (pcd_o),
    .pwt_o     (pwt_o),
    .attr_oe_o (attr_oe_o)
  );
endmodule

// File: tb/cache_fill_ctrl_test.sv
module cache_fill_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cycle_start = 0, rd = 0, cach = 0, lk = 0, cache_en_n = 1, rdy = 0;
  logic flush_n = 1, pg_en = 0, unpg = 0, pg_pcd = 0, pg_pwt = 0;
  logic cr_pcd = 0, cr_pwt = 0, cd = 0, hold = 0;
  logic fill_active, commit, flush, test_mode, pcd, pwt, attr_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cache_fill_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cycle_start_i(cycle_start), .read_i(rd),
    .cacheable_i(cach), .locked_i(lk), .cache_en_ni(cache_en_n), .rdy_i(rdy),
    .flush_ni(flush_n), .paging_en_i(pg_en), .unpaged_i(unpg),
    .pg_pcd_i(pg_pcd), .pg_pwt_i(pg_pwt), .cr_pcd_i(cr_pcd), .cr_pwt_i(cr_pwt),
    .cache_dis_i(cd), .hold_i(hold),
    .fill_active_o(fill_active), .line_commit_o(commit), .flush_o(flush),
    .test_mode_o(test_mode), .pcd_o(pcd), .pwt_o(pwt), .attr_oe_o(attr_oe)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // one bus cycle; kl = cache enable active in the clock before the last ready
  task automatic run_cycle(input bit r, input bit c, input bit l, input bit ks, input bit kl);
    bit exp_fill;
    exp_fill = r & c & ~l & ks;
    @(negedge clk);
    cycle_start = 1; rd = r; cach = c; lk = l; cache_en_n = ~ks;
    @(negedge clk);
    cycle_start = 0; cache_en_n = 1;
    chk(l ? "R3" : (exp_fill ? "R1" : "R2"), fill_active, exp_fill);
    if (exp_fill) begin
      for (int b = 0; b < 4; b++) begin
        if (b == 2) begin
          rdy = 0; cache_en_n = 1;
          @(negedge clk);
          chk("R1 wait", fill_active, 1'b1);
        end
        rdy = 1;
        cache_en_n = (b == 2) ? ~kl : kl;
        @(negedge clk);
        if (b < 3) begin
          chk("R1 beat", fill_active, 1'b1);
          chk("R4 early", commit, 1'b0);
        end
      end
      rdy = 0; cache_en_n = 1;
      chk("R1 end", fill_active, 1'b0);
      chk("R4 commit", commit, kl);
      @(negedge clk);
      chk("R4 pulse", commit, 1'b0);
    end else begin
      rdy = 1;
      @(negedge clk);
      rdy = 0;
      chk("R2 end", fill_active, 1'b0);
      chk("R4 nofill", commit, 1'b0);
    end
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 fill", fill_active, 1'b0);
    chk("R10 commit", commit, 1'b0);
    chk("R10 flush", flush, 1'b0);
    chk("R10 pcd", pcd, 1'b0);
    chk("R10 pwt", pwt, 1'b0);
    chk("R10 oe", attr_oe, 1'b1);
    rst_ni = 1;
    @(negedge clk);
    chk("R6 no test mode", test_mode, 1'b0);

    // fill / commit sweep
    for (int i = 0; i < 32; i++)
      run_cycle(i[0], i[1], i[2], i[3], i[4]);

    // attribute sweep
    for (int i = 0; i < 128; i++) begin
      bit usep, epcd, epwt;
      usep = i[0] & ~i[1];
      epcd = (usep ? i[2] : i[4]) & ~i[6];
      epwt = usep ? i[3] : i[5];
      @(negedge clk);
      cycle_start = 1; rd = 0; lk = 0;
      pg_en = i[0]; unpg = i[1]; pg_pcd = i[2]; pg_pwt = i[3];
      cr_pcd = i[4]; cr_pwt = i[5]; cd = i[6];
      @(negedge clk);
      cycle_start = 0;
      chk(i[6] ? "R8" : "R7 pcd", pcd, epcd);
      chk("R7 pwt", pwt, epwt);
      pg_pcd = ~i[2]; pg_pwt = ~i[3]; cr_pcd = ~i[4]; cr_pwt = ~i[5]; cd = 0;
      rdy = 1;
      @(negedge clk);
      rdy = 0;
      chk("R7 held pcd", pcd, epcd);
      chk("R7 held pwt", pwt, epwt);
    end

    // start while a fill is in progress is ignored
    @(negedge clk);
    pg_en = 0; unpg = 0; cr_pcd = 1; cr_pwt = 1; cd = 0;
    cycle_start = 1; rd = 1; cach = 1; lk = 0; cache_en_n = 0;
    @(negedge clk);
    cr_pcd = 0; cr_pwt = 0; cache_en_n = 1;
    @(negedge clk);
    cycle_start = 0;
    chk("R7 busy pcd", pcd, 1'b1);
    chk("R7 busy pwt", pwt, 1'b1);
    chk("R1 busy fill", fill_active, 1'b1);
    rdy = 1;
    repeat (4) @(negedge clk);
    rdy = 0;
    chk("R2 busy end", fill_active, 1'b0);
    @(negedge clk);
    chk("R2 no extra cycle", fill_active, 1'b0);

    // bus hold
    hold = 1;
    @(negedge clk);
    chk("R9 hold", attr_oe, 1'b0);
    @(negedge clk);
    chk("R9 hold kept", attr_oe, 1'b0);
    hold = 0;
    @(negedge clk);
    chk("R9 release", attr_oe, 1'b1);

    // flush held low
    flush_n = 0;
    @(negedge clk); chk("R5 k", flush, 1'b0);
    @(negedge clk); chk("R5 k+1", flush, 1'b0);
    @(negedge clk); chk("R5 pulse", flush, 1'b1);
    @(negedge clk); chk("R5 single", flush, 1'b0);
    flush_n = 1;
    repeat (3) begin @(negedge clk); chk("R5 release", flush, 1'b0); end

    // one-clock flush request
    flush_n = 0;
    @(negedge clk); flush_n = 1; chk("R5 short k", flush, 1'b0);
    @(negedge clk); chk("R5 short k+1", flush, 1'b0);
    @(negedge clk); chk("R5 short pulse", flush, 1'b1);
    @(negedge clk); chk("R5 short end", flush, 1'b0);

    // flush held across reset release selects test mode
    rst_ni = 0; flush_n = 0;
    repeat (5) @(negedge clk);
    chk("R10 flush in reset", flush, 1'b0);
    rst_ni = 1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk("R6 test mode", test_mode, 1'b1);
      chk("R6 no flush", flush, 1'b0);
    end
    flush_n = 1;
    repeat (4) @(negedge clk);
    chk("R6 test mode held", test_mode, 1'b1);
    chk("R6 no flush after", flush, 1'b0);

    // normal reset clears test mode
    rst_ni = 0;
    repeat (5) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R6 cleared", test_mode, 1'b0);
    run_cycle(1, 1, 0, 1, 1);

    finish_run();
  end
endmodule